// File: doc/BRIEF.md
# I2C Command-Register Target

This block is an I2C target that lets a host reach a space of 128 one-byte command locations. It samples the raw SCL and SDA lines with the system clock through synchronizer flops. It finds START, repeated START and STOP conditions from SDA edges seen while SCL is high. The block pulls SDA low through an open-drain enable to acknowledge bytes and to return read data. A single command pointer selects the location. The host sets the pointer with a command byte, and each acknowledged data byte moves it forward by one.

The register storage sits outside the block. It is reached through a small port: the location index, write data, a one-clock write strobe, read data, and a read-only flag that the storage returns for the indexed location. The block enforces the access rules at the bus. It refuses out-of-range commands, writes to read-only locations and surplus write bytes. A programmable watchdog drops the transfer and releases SDA when the bus stays stuck low.

Top module: `i2c_cmd_target`

## Requirements
- R1: The block answers only to the 7-bit address 0x55, so its address byte is 0xAA for a write and 0xAB for a read (the address sits in bits 7..1 and the direction in bit 0, where 1 means read). Any other address gets no ACK on any byte, and there is no write strobe until the next START.
- R2: A single write (START, 0xAA, command, one data byte, STOP) is ACKed on all three bytes. It gives exactly one `reg_we` pulse of one clock, during which `reg_addr` equals the command and `reg_wdata` equals the data byte.
- R3: A command byte with bit 7 set is NACKed. The pointer keeps its value, and the rest of the transfer is ignored until the next START or STOP.
- R4: When `reg_ro` is high for the addressed location, the command byte is still ACKed. The first data byte is then NACKed, no write strobe is issued, and the pointer does not advance.
- R5: In a write, every data byte after the first is NACKed and never reaches the register port.
- R6: The pointer rises by one for each acknowledged data byte. That is a byte the block ACKs in a write, or a byte the master ACKs in a read. A byte the master NACKs leaves the pointer unchanged.
- R7: A quick read (START, 0xAB, data) returns the byte at the current pointer, with no command byte.
- R8: A combined read (START, 0xAA, command, repeated START, 0xAB) returns the commanded location first. It returns the following locations for as long as the master ACKs.
- R9: Once the pointer reaches 0x7F, the next location it gives is 0x00, both in an incremental read and after a write.
- R10: When the synchronized SCL and SDA are both low for `stuck_limit` system clocks, the block releases SDA and drops the transfer. Until that count is reached, it keeps driving. A limit of zero turns the watchdog off.
- R11: After reset and after any STOP, SDA is released and `reg_we` is low. After reset the pointer is 0.
- R12: Read data goes out MSB first. The block changes its SDA drive only after a falling SCL edge, never while SCL stays high, except when a START, STOP or watchdog expiry releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | When high, the block pulls SDA low |
| stuck_limit | input | TO_W (16) | Stuck-low timeout in system clocks; 0 disables it |
| reg_addr | output | PTR_W (7) | Location index, equal to the command pointer |
| reg_wdata | output | 8 | Write data, valid while `reg_we` is high |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 8 | Data of the location at `reg_addr` |
| reg_ro | input | 1 | High when the location at `reg_addr` is read-only |

## Verification
A wrong pointer stays hidden until the next read: the first quick read or combined read after the faulty step returns the wrong location's byte. A miscounted bit or a wrong state shows within one byte, as an ACK in the wrong bit slot or as a read byte that is shifted. A watchdog that counts wrongly shows as SDA still held low long after the limit, or released well before it, while the master parks SCL low during an acknowledge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK,
      ST_IGNORE
   } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_hi,
   output logic sda_hi,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   // idle bus level is high, so the chain resets to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_hi    = scl_pipe[STAGES-1];
   assign sda_hi    = sda_pipe[STAGES-1];
   assign scl_rise  = scl_hi & ~scl_q;
   assign scl_fall  = ~scl_hi & scl_q;
   // conditions: SDA edge while SCL held high on both samples
   assign bus_start = scl_hi & scl_q & sda_q & ~sda_hi;
   assign bus_stop  = scl_hi & scl_q & ~sda_q & sda_hi;

endmodule

// File: rtl/i2c_tgt_wdog.sv
module i2c_tgt_wdog #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_hi,
   input  logic             sda_hi,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("i2c_tgt_wdog: CNT_W must lie in 4..32");
      end
   endgenerate

   logic [CNT_W-1:0] low_cnt;
   logic             both_low;
   logic             armed;

   assign both_low = ~scl_hi & ~sda_hi;
   assign armed    = (limit != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         expire  <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (!both_low || !armed) begin
            low_cnt <= '0;
         end else if (low_cnt != limit) begin
            low_cnt <= low_cnt + 1'b1;
            if (low_cnt == limit - 1'b1) expire <= 1'b1;
         end
      end
   end

   // R10: one expiry per stuck episode
   p_expire_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   // R10: an expiry only follows a cycle with both lines low
   p_expire_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expire) |-> $past(both_low));

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h55,
   parameter int         PTR_W       = 7,
   parameter int         SYNC_STAGES = 2,
   parameter int         TO_W        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [TO_W-1:0]   stuck_limit,
   output logic [PTR_W-1:0]  reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata,
   input  logic              reg_ro
);

   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

   generate
      if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_ptr
         $error("i2c_cmd_target: PTR_W must lie in 1..8");
      end
   endgenerate

   logic scl_hi, sda_hi, scl_rise, scl_fall, bus_start, bus_stop;
   logic expire;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_hi    (scl_hi),
      .sda_hi    (sda_hi),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   i2c_tgt_wdog #(.CNT_W(TO_W)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_hi (scl_hi),
      .sda_hi (sda_hi),
      .limit  (stuck_limit),
      .expire (expire)
   );

   tgt_state_e              state;
   logic [BIT_CNT_W-1:0]    bit_cnt;
   logic [BYTE_W-1:0]       rx_byte;
   logic [BYTE_W-1:0]       tx_byte;
   logic [PTR_W-1:0]        ptr;
   logic                    dir_rd;
   logic                    first_wr;
   logic                    wr_taken;
   logic                    host_ack;
   logic                    cmd_bad;
   logic                    byte_done;

   // command range check: a full 8-bit pointer accepts every command
   generate
      if (PTR_W < BYTE_W) begin : g_cmd_range
         assign cmd_bad = |rx_byte[BYTE_W-1:PTR_W];
      end else begin : g_cmd_full
         assign cmd_bad = 1'b0;
      end
   endgenerate

   assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
   assign reg_addr  = ptr;
   assign reg_wdata = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_byte  <= '0;
         tx_byte  <= '0;
         ptr      <= '0;
         dir_rd   <= 1'b0;
         first_wr <= 1'b0;
         wr_taken <= 1'b0;
         host_ack <= 1'b0;
         sda_oe   <= 1'b0;
         reg_we   <= 1'b0;
      end else begin
         reg_we <= 1'b0;
         if (expire) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
         end else if (bus_start) begin
            state   <= ST_ADDR;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
         end else if (bus_stop) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise) begin
                     rx_byte <= {rx_byte[BYTE_W-2:0], sda_hi};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     bit_cnt <= '0;
                     if (state == ST_ADDR) begin
                        if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                           dir_rd <= rx_byte[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else if (state == ST_CMD) begin
                        if (cmd_bad) begin
                           state <= ST_IGNORE;
                        end else begin
                           ptr    <= rx_byte[PTR_W-1:0];
                           sda_oe <= 1'b1;
                           state  <= ST_CMD_ACK;
                        end
                     end else begin
                        // only the first byte to a writable location lands
                        if (first_wr && !reg_ro) begin
                           sda_oe   <= 1'b1;
                           reg_we   <= 1'b1;
                           wr_taken <= 1'b1;
                        end else begin
                           wr_taken <= 1'b0;
                        end
                        first_wr <= 1'b0;
                        state    <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (dir_rd) begin
                        tx_byte <= reg_rdata;
                        sda_oe  <= ~reg_rdata[BYTE_W-1];
                        state   <= ST_RDATA;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK: begin
                  if (scl_fall) begin
                     sda_oe   <= 1'b0;
                     first_wr <= 1'b1;
                     state    <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     if (wr_taken) ptr <= ptr + 1'b1;
                     wr_taken <= 1'b0;
                     state    <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_RACK;
                     end else begin
                        tx_byte <= {tx_byte[BYTE_W-2:0], 1'b0};
                        sda_oe  <= ~tx_byte[BYTE_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_hi;
                     if (!sda_hi) ptr <= ptr + 1'b1;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        tx_byte <= reg_rdata;
                        sda_oe  <= ~reg_rdata[BYTE_W-1];
                        state   <= ST_RDATA;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

   // R2: a write strobe lasts a single clock
   p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R4: the storage never sees a strobe for a read-only location
   p_we_not_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !reg_ro);

   // R10: watchdog expiry frees SDA on the next clock
   p_wdog_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !sda_oe);

   // R11: a STOP frees SDA
   p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !sda_oe);

   // R12: drive changes only follow a low SCL sample or a bus event
   p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_hi) && !$past(bus_start) && !$past(bus_stop) && !$past(expire))
         |-> $stable(sda_oe));

endmodule

// File: tb/tb_i2c_cmd_target.sv
module tb_i2c_cmd_target;

   localparam int Q = 10;
   localparam int NVEC = 12;
   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_QR = 2'd2;
   // {op, command, data}
   localparam logic [17:0] VEC [0:NVEC-1] = '{
      {OP_WR, 8'h50, 8'hC3},
      {OP_RD, 8'h50, 8'h00},
      {OP_WR, 8'h10, 8'h77},
      {OP_RD, 8'h10, 8'h00},
      {OP_WR, 8'h7F, 8'h9E},
      {OP_RD, 8'h7F, 8'h00},
      {OP_QR, 8'h00, 8'h00},
      {OP_WR, 8'h21, 8'h44},
      {OP_QR, 8'h00, 8'h00},
      {OP_RD, 8'h00, 8'h00},
      {OP_WR, 8'h20, 8'h01},
      {OP_RD, 8'h1F, 8'h00}
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic [15:0] limit = 16'd200;
   logic [6:0]  reg_addr;
   logic [7:0]  reg_wdata, reg_rdata;
   logic        reg_we, reg_ro;
   wire         sda_bus = sda_m & ~sda_oe;

   logic [7:0] mem    [0:127];
   logic [7:0] shadow [0:127];
   logic [7:0] rbuf   [0:7];
   int         we_cnt = 0;
   int         checks = 0;
   int         fails  = 0;
   bit         done   = 1'b0;
   logic [6:0] ptr_m;

   i2c_cmd_target dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .stuck_limit(limit), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_ro(reg_ro)
   );

   assign reg_rdata = mem[reg_addr];
   assign reg_ro    = (reg_addr < 7'h20);

   always @(posedge clk) begin
      if (rst_n && reg_we) begin
         mem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
   end

   function automatic logic [7:0] init_val(input int a);
      return 8'((a * 37) ^ 8'hA6);
   endfunction

   function automatic bit is_ro(input logic [7:0] a);
      return a < 8'h20;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_rstart();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(2 * Q);
         scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b);
      tick(Q);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~sda_bus; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      logic [7:0] v = '0;
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         v = {v[6:0], sda_bus}; tick(Q);
         scl_m = 1'b0;
      end
      sda_m = ~mack; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
      b = v;
   endtask

   task automatic do_write(input logic [7:0] cmd, input logic [7:0] d,
                           output bit aa, output bit ac, output bit ad);
      bus_start();
      send_byte(8'hAA, aa);
      send_byte(cmd, ac);
      send_byte(d, ad);
      bus_stop();
   endtask

   task automatic do_read(input logic [7:0] cmd, input int n, output bit hdr_ok);
      bit a1, a2, a3;
      bus_start();
      send_byte(8'hAA, a1);
      send_byte(cmd, a2);
      bus_rstart();
      send_byte(8'hAB, a3);
      for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
      bus_stop();
      hdr_ok = a1 && a2 && a3;
   endtask

   task automatic quick_read(output logic [7:0] b, output bit aa);
      bus_start();
      send_byte(8'hAB, aa);
      recv_byte(1'b0, b);
      bus_stop();
   endtask

   task automatic wrap_up();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         wrap_up();
      end
   end

   initial begin
      bit aa, ac, ad, hok;
      logic [7:0] got;
      int we0;
      for (int a = 0; a < 128; a++) begin
         mem[a]    = init_val(a);
         shadow[a] = init_val(a);
      end
      rst_n = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R11: reset state at the ports
      check(sda_oe == 1'b0, "R11 sda_oe after reset", sda_oe, 0);
      check(reg_we == 1'b0, "R11 reg_we after reset", reg_we, 0);
      check(reg_addr == 7'h00, "R11 pointer after reset", reg_addr, 0);
      ptr_m = 7'h00;
      quick_read(got, aa);
      check(aa && got == shadow[0], "R7 quick read after reset", got, shadow[0]);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] op;
         logic [7:0] c, d;
         bit exp_ack;
         op = VEC[i][17:16];
         c  = VEC[i][15:8];
         d  = VEC[i][7:0];
         case (op)
            OP_WR: begin
               we0 = we_cnt;
               do_write(c, d, aa, ac, ad);
               exp_ack = !is_ro(c);
               check(aa && ac, "R2 address and command ACK", {aa, ac}, 3);
               check(ad == exp_ack, exp_ack ? "R2 data ACK" : "R4 read-only data NACK",
                     ad, exp_ack);
               check(we_cnt - we0 == int'(exp_ack), "R2 R4 strobe count",
                     we_cnt - we0, exp_ack);
               if (exp_ack) begin
                  shadow[c] = d;
                  ptr_m = 7'(c + 1);
               end else begin
                  ptr_m = c[6:0];
               end
            end
            OP_RD: begin
               do_read(c, 1, hok);
               check(hok && rbuf[0] == shadow[c], "R8 R12 combined read", rbuf[0], shadow[c]);
               ptr_m = c[6:0];
            end
            default: begin
               quick_read(got, aa);
               check(aa && got == shadow[ptr_m], "R6 R7 quick read at pointer",
                     got, shadow[ptr_m]);
            end
         endcase
      end

      // R1: foreign address is ignored
      we0 = we_cnt;
      bus_start();
      send_byte(8'hAC, aa);
      send_byte(8'h50, ac);
      send_byte(8'h11, ad);
      bus_stop();
      check(!aa && !ac && !ad, "R1 no ACK for foreign address", {aa, ac, ad}, 0);
      check(we_cnt == we0, "R1 no strobe for foreign address", we_cnt - we0, 0);

      // R3: out-of-range command
      bus_start();
      send_byte(8'hAA, aa);
      send_byte(8'h85, ac);
      bus_stop();
      check(aa && !ac, "R3 command above 0x7F NACKed", {aa, ac}, 2);
      quick_read(got, aa);
      check(got == shadow[ptr_m], "R3 pointer unchanged", got, shadow[ptr_m]);

      // R5: surplus write bytes
      we0 = we_cnt;
      bus_start();
      send_byte(8'hAA, aa);
      send_byte(8'h60, ac);
      send_byte(8'hA5, ad);
      send_byte(8'h5A, hok);
      bus_stop();
      check(ad && !hok, "R5 second data byte NACKed", {ad, hok}, 2);
      check(we_cnt - we0 == 1, "R5 single strobe", we_cnt - we0, 1);
      shadow[8'h60] = 8'hA5;
      do_read(8'h60, 2, hok);
      check(rbuf[0] == 8'hA5, "R5 first byte stored", rbuf[0], 8'hA5);
      check(rbuf[1] == shadow[8'h61], "R5 next location untouched", rbuf[1], shadow[8'h61]);

      // R9: incremental read across the top of the space
      do_read(8'h7E, 4, hok);
      check(rbuf[0] == shadow[8'h7E], "R8 incremental byte 0", rbuf[0], shadow[8'h7E]);
      check(rbuf[1] == shadow[8'h7F], "R9 incremental 0x7F", rbuf[1], shadow[8'h7F]);
      check(rbuf[2] == shadow[8'h00], "R9 wrap to 0x00", rbuf[2], shadow[8'h00]);
      check(rbuf[3] == shadow[8'h01], "R9 after wrap 0x01", rbuf[3], shadow[8'h01]);
      quick_read(got, aa);
      check(got == shadow[8'h01], "R6 master NACK keeps pointer", got, shadow[8'h01]);

      // R10: stuck-low watchdog during an address ACK
      bus_start();
      send_bits(8'hAA);
      sda_m = 1'b1;
      tick(100);
      check(sda_bus == 1'b0, "R10 ACK held before limit", sda_bus, 0);
      tick(200);
      check(sda_bus == 1'b1, "R10 SDA released after limit", sda_bus, 1);
      bus_stop();
      check(sda_oe == 1'b0, "R11 released after STOP", sda_oe, 0);
      do_read(8'h50, 1, hok);
      check(hok && rbuf[0] == shadow[8'h50], "R10 transfer after timeout", rbuf[0], shadow[8'h50]);

      done = 1'b1;
      wrap_up();
   end

endmodule